// File: doc/BRIEF.md
# Host Command and Interrupt Status Unit

This block is the command and status point of a network adapter's host interface. The host writes a 16-bit command word. The block splits that word into a 5-bit opcode in the top bits and an 11-bit argument in the low bits. From these commands it keeps several pieces of state:

- which register window is selected;
- whether receive and transmit are enabled;
- an 8-bit interrupt mask;
- a 4-bit receive filter;
- eight latched event bits.

The host reads a 16-bit status word back from the same place. That word carries the selected window in bits 15:13, a command-in-progress flag in bit 12, zeros in bits 11:8 and the latched events in bits 7:0.

Datapath strobes set the event bits, and the host clears them again with a bitmask acknowledge. An interrupt line combines the masked events with the latch bit. The three reset commands keep the command-in-progress flag high for a parameterised number of cycles. While the flag is high, further command writes are dropped.

Top module: `hcu_cmd_status`

## Requirements
- R1: After `rst_n` is released, every output is zero: the window is 0, receive and transmit are off, the mask, filter and events are 0, and `busy` and `irq` are 0.
- R2: Opcode 1 (`cmd_data[15:11]`) loads the window from argument bits 2:0 and ignores the higher argument bits. `window` and `status[15:13]` both show the selected window.
- R3: Opcodes 4 and 3 enable and disable receive. Opcodes 9 and 10 enable and disable transmit. These commands ignore their argument. Unassigned opcodes (2, 6, 7, 8, 15, 17 to 31) change nothing.
- R4: Opcode 14 loads `int_mask` from argument bits 7:0. Opcode 16 loads `rx_filter` from argument bits 3:0, where bit 0 is individual, bit 1 multicast, bit 2 broadcast and bit 3 promiscuous.
- R5: A high `evt_in[i]` at a clock edge sets `status[i]` for i in 1 to 5 and 7. The set bit stays set until it is cleared. `evt_in[0]` and `evt_in[6]` have no effect.
- R6: Opcode 12 sets `status[6]`, the interrupt-requested bit.
- R7: `status[0]` is the interrupt latch. It sets on any edge where an arriving event, from `evt_in` or opcode 12, falls on a bit whose `int_mask` bit is 1.
- R8: `irq` is high exactly when `status[0]` is 1, or when some bit of `status[7:1]` is set and its `int_mask` bit is also 1.
- R9: Opcode 13 clears each `status[7:0]` bit whose argument bit is 1. An event arriving in the same cycle wins, so its bit stays set.
- R10: Opcodes 0, 5 and 11 hold `busy` (`status[12]`) high for exactly RST_CYCLES cycles, starting at the next edge. No other command raises it. A write while `busy` is high is ignored.
- R11: Opcode 5 turns receive off and opcode 11 turns transmit off. Opcode 0 clears all of the following, and drops any event that arrives in the same cycle:
  - the window, mask and filter;
  - every event bit;
  - receive and transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode in 15:11, argument in 10:0 |
| evt_in | input | 8 | Event strobes from the datapath, one per status bit |
| status | output | 16 | Window, busy flag and latched events |
| irq | output | 1 | Interrupt request |
| window | output | 3 | Selected register window |
| rx_en | output | 1 | Receive enabled |
| tx_en | output | 1 | Transmit enabled |
| int_mask | output | 8 | Interrupt mask |
| rx_filter | output | 4 | Receive filter bits |
| busy | output | 1 | Command in progress |

## Verification
The concurrency that matters is an acknowledge command and a datapath event strobe landing on the same clock edge. The bench drives both in one cycle, in two forms: once on the same bit, where the bit must survive, and once on different bits, where the acknowledged bit must clear and the new one must set. A second collision is a global reset meeting an event strobe, where the reset must win. Expected status words are built in the bench from the masks it applied.

// File: rtl/hcu_pkg.sv
package hcu_pkg;

   localparam logic [4:0] OP_GRESET = 5'd0;
   localparam logic [4:0] OP_WINSEL = 5'd1;
   localparam logic [4:0] OP_RXOFF  = 5'd3;
   localparam logic [4:0] OP_RXON   = 5'd4;
   localparam logic [4:0] OP_RXRST  = 5'd5;
   localparam logic [4:0] OP_TXON   = 5'd9;
   localparam logic [4:0] OP_TXOFF  = 5'd10;
   localparam logic [4:0] OP_TXRST  = 5'd11;
   localparam logic [4:0] OP_REQINT = 5'd12;
   localparam logic [4:0] OP_ACK    = 5'd13;
   localparam logic [4:0] OP_MASK   = 5'd14;
   localparam logic [4:0] OP_FILTER = 5'd16;

   typedef struct packed {
      logic greset;
      logic winsel;
      logic rx_off;
      logic rx_on;
      logic rx_rst;
      logic tx_on;
      logic tx_off;
      logic tx_rst;
      logic req;
      logic ack;
      logic mask;
      logic filt;
   } hcu_dec_t;

endpackage

// File: rtl/hcu_decoder.sv
module hcu_decoder
   import hcu_pkg::*;
#(
   parameter int CMD_W = 16,
   parameter int OP_W  = 5,
   localparam int ARG_W = CMD_W - OP_W
) (
   input  logic             valid,
   input  logic [CMD_W-1:0] cmd,
   output hcu_dec_t         dec,
   output logic [ARG_W-1:0] arg
);

   if (OP_W != 5) begin : g_bad_op
      $error("hcu_decoder: opcode field must be 5 bits");
   end

   logic [OP_W-1:0] op;

   assign op  = cmd[CMD_W-1 -: OP_W];
   assign arg = cmd[ARG_W-1:0];

   always_comb begin
      dec        = '0;
      dec.greset = valid && (op == OP_GRESET);
      dec.winsel = valid && (op == OP_WINSEL);
      dec.rx_off = valid && (op == OP_RXOFF);
      dec.rx_on  = valid && (op == OP_RXON);
      dec.rx_rst = valid && (op == OP_RXRST);
      dec.tx_on  = valid && (op == OP_TXON);
      dec.tx_off = valid && (op == OP_TXOFF);
      dec.tx_rst = valid && (op == OP_TXRST);
      dec.req    = valid && (op == OP_REQINT);
      dec.ack    = valid && (op == OP_ACK);
      dec.mask   = valid && (op == OP_MASK);
      dec.filt   = valid && (op == OP_FILTER);
   end

endmodule

// File: rtl/hcu_busy_timer.sv
module hcu_busy_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("hcu_busy_timer: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy <= 1'b0;
         else        busy <= start;
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(CYCLES + 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (start)      cnt <= CNT_W'(CYCLES);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end

      assign busy = (cnt != '0);
   end

endmodule

// File: rtl/hcu_event_bank.sv
module hcu_event_bank #(
   parameter int EV_W      = 8,
   parameter int LATCH_BIT = 0,
   parameter int REQ_BIT   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_all,
   input  logic [EV_W-1:0] evt_in,
   input  logic            req,
   input  logic            ack_en,
   input  logic [EV_W-1:0] ack_mask,
   input  logic [EV_W-1:0] mask,
   output logic [EV_W-1:0] ev,
   output logic            irq
);

   if (LATCH_BIT >= EV_W || REQ_BIT >= EV_W || LATCH_BIT == REQ_BIT) begin : g_bad_bits
      $error("hcu_event_bank: latch and request bits must be distinct and in range");
   end

   localparam logic [EV_W-1:0] SRC_SEL = ~(EV_W'(1) << LATCH_BIT);

   logic [EV_W-1:0] arrive;
   logic            hit;
   logic            unused_evt;

   assign unused_evt = evt_in[LATCH_BIT] ^ evt_in[REQ_BIT];

   for (genvar i = 0; i < EV_W; i++) begin : g_src
      if (i == LATCH_BIT) begin : g_latch_src
         assign arrive[i] = 1'b0;
      end else if (i == REQ_BIT) begin : g_req_src
         assign arrive[i] = req;
      end else begin : g_evt_src
         assign arrive[i] = evt_in[i];
      end
   end

   assign hit = |(arrive & mask);

   for (genvar i = 0; i < EV_W; i++) begin : g_bit
      logic set_i;
      if (i == LATCH_BIT) begin : g_set_latch
         assign set_i = hit;
      end else begin : g_set_src
         assign set_i = arrive[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     ev[i] <= 1'b0;
         else if (clr_all)               ev[i] <= 1'b0;
         else if (set_i)                 ev[i] <= 1'b1;
         else if (ack_en && ack_mask[i]) ev[i] <= 1'b0;
      end
   end

   assign irq = ev[LATCH_BIT] | (|(ev & mask & SRC_SEL));

endmodule

// File: rtl/hcu_cmd_status.sv
module hcu_cmd_status
   import hcu_pkg::*;
#(
   parameter int CMD_W      = 16,
   parameter int OP_W       = 5,
   parameter int WIN_W      = 3,
   parameter int EV_W       = 8,
   parameter int FILT_W     = 4,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic [EV_W-1:0]   evt_in,
   output logic [CMD_W-1:0]  status,
   output logic              irq,
   output logic [WIN_W-1:0]  window,
   output logic              rx_en,
   output logic              tx_en,
   output logic [EV_W-1:0]   int_mask,
   output logic [FILT_W-1:0] rx_filter,
   output logic              busy
);

   localparam int ARG_W = CMD_W - OP_W;
   localparam int PAD_W = CMD_W - WIN_W - 1 - EV_W;

   if (PAD_W < 1) begin : g_bad_status
      $error("hcu_cmd_status: status word too narrow for window, busy and events");
   end
   if (ARG_W < EV_W || ARG_W < FILT_W || ARG_W < WIN_W) begin : g_bad_arg
      $error("hcu_cmd_status: argument field too narrow");
   end

   logic             accept;
   hcu_dec_t         dec;
   logic [ARG_W-1:0] arg;
   logic             unused_arg_bits;

   assign accept          = cmd_wr & ~busy;
   assign unused_arg_bits = ^arg;

   hcu_decoder #(
      .CMD_W (CMD_W),
      .OP_W  (OP_W)
   ) u_dec (
      .valid (accept),
      .cmd   (cmd_data),
      .dec   (dec),
      .arg   (arg)
   );

   hcu_busy_timer #(
      .CYCLES (RST_CYCLES)
   ) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (dec.greset | dec.rx_rst | dec.tx_rst),
      .busy  (busy)
   );

   logic [EV_W-1:0] ev;

   hcu_event_bank #(
      .EV_W      (EV_W),
      .LATCH_BIT (0),
      .REQ_BIT   (6)
   ) u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (dec.greset),
      .evt_in   (evt_in),
      .req      (dec.req),
      .ack_en   (dec.ack),
      .ack_mask (arg[EV_W-1:0]),
      .mask     (int_mask),
      .ev       (ev),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         window    <= '0;
         rx_en     <= 1'b0;
         tx_en     <= 1'b0;
         int_mask  <= '0;
         rx_filter <= '0;
      end else if (dec.greset) begin
         window    <= '0;
         rx_en     <= 1'b0;
         tx_en     <= 1'b0;
         int_mask  <= '0;
         rx_filter <= '0;
      end else begin
         if (dec.winsel)                 window    <= arg[WIN_W-1:0];
         if (dec.rx_off || dec.rx_rst)   rx_en     <= 1'b0;
         else if (dec.rx_on)             rx_en     <= 1'b1;
         if (dec.tx_off || dec.tx_rst)   tx_en     <= 1'b0;
         else if (dec.tx_on)             tx_en     <= 1'b1;
         if (dec.mask)                   int_mask  <= arg[EV_W-1:0];
         if (dec.filt)                   rx_filter <= arg[FILT_W-1:0];
      end
   end

   assign status = {window, busy, {PAD_W{1'b0}}, ev};

endmodule

// File: rtl/hcu_cmd_status_chk.sv
module hcu_cmd_status_chk #(
   parameter int CMD_W  = 16,
   parameter int WIN_W  = 3,
   parameter int EV_W   = 8,
   parameter int FILT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_wr,
   input logic [CMD_W-1:0]  cmd_data,
   input logic [EV_W-1:0]   evt_in,
   input logic [CMD_W-1:0]  status,
   input logic              irq,
   input logic [WIN_W-1:0]  window,
   input logic              rx_en,
   input logic              tx_en,
   input logic [EV_W-1:0]   int_mask,
   input logic [FILT_W-1:0] rx_filter,
   input logic              busy
);

   logic [4:0] op;
   assign op = cmd_data[CMD_W-1 -: 5];

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> ($stable(window) && $stable(int_mask) &&
                            $stable(rx_filter) && $stable(rx_en) && $stable(tx_en)));

   // R10
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cmd_wr) &&
                       ($past(op) == 5'd0 || $past(op) == 5'd5 || $past(op) == 5'd11)));

   // R11
   greset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy && op == 5'd0) |=> (window == '0 && int_mask == '0 &&
         rx_filter == '0 && !rx_en && !tx_en && status[EV_W-1:0] == '0 && busy));

   // R7
   latch_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in[2] && int_mask[2] && !(cmd_wr && !busy && op == 5'd0))
         |=> (status[0] && irq));

   // R9
   ack_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy && op == 5'd13 && cmd_data[EV_W-1:0] == '1 && evt_in == '0)
         |=> (status[EV_W-1:0] == '0 && !irq));

   // R2
   window_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(window) |-> ($past(cmd_wr) && !$past(busy) &&
                            ($past(op) == 5'd1 || $past(op) == 5'd0)));

endmodule

bind hcu_cmd_status hcu_cmd_status_chk #(
   .CMD_W  (CMD_W),
   .WIN_W  (WIN_W),
   .EV_W   (EV_W),
   .FILT_W (FILT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .cmd_data  (cmd_data),
   .evt_in    (evt_in),
   .status    (status),
   .irq       (irq),
   .window    (window),
   .rx_en     (rx_en),
   .tx_en     (tx_en),
   .int_mask  (int_mask),
   .rx_filter (rx_filter),
   .busy      (busy)
);

// File: tb/tb_hcu_cmd_status.sv
module tb_hcu_cmd_status;

   localparam int RSTC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [15:0] cmd_data = '0;
   logic [7:0]  evt_in = '0;
   logic [15:0] status;
   logic        irq;
   logic [2:0]  window;
   logic        rx_en;
   logic        tx_en;
   logic [7:0]  int_mask;
   logic [3:0]  rx_filter;
   logic        busy;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   hcu_cmd_status #(.RST_CYCLES(RSTC)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .evt_in(evt_in), .status(status), .irq(irq), .window(window),
      .rx_en(rx_en), .tx_en(tx_en), .int_mask(int_mask),
      .rx_filter(rx_filter), .busy(busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one cycle of command and events, return at the negedge after the edge
   task automatic cycle(input logic wr, input logic [15:0] c, input logic [7:0] e);
      cmd_wr = wr; cmd_data = c; evt_in = e;
      @(negedge clk);
      cmd_wr = 1'b0; cmd_data = '0; evt_in = '0;
   endtask

   task automatic send(input logic [4:0] op, input logic [10:0] a);
      cycle(1'b1, {op, a}, 8'h00);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   function automatic logic exp_irq(input logic [7:0] ev, input logic [7:0] m);
      return ev[0] | (|(ev & m & 8'hFE));
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 status", status, 16'h0000);
      check("R1 irq", irq, 0);
      check("R1 rx_en/tx_en", {rx_en, tx_en}, 0);
      check("R1 mask/filter", {int_mask, rx_filter}, 0);
      check("R1 busy", busy, 0);

      // R2 window select sweep with junk in upper argument bits
      for (int w = 0; w < 8; w++) begin
         send(5'd1, {8'(w * 37 + 5), 3'(w)});
         check("R2 window", window, w);
         check("R2 status window", status[15:13], w);
      end

      // R3 enables, argument ignored
      send(5'd4, 11'h7FF);
      check("R3 rx on", {rx_en, tx_en}, 2'b10);
      check("R3 window kept", window, 3'd7);
      send(5'd9, 11'h7FF);
      check("R3 tx on", {rx_en, tx_en}, 2'b11);
      send(5'd3, 11'h555);
      check("R3 rx off", {rx_en, tx_en}, 2'b01);
      send(5'd10, 11'h2AA);
      check("R3 tx off", {rx_en, tx_en}, 2'b00);
      send(5'd4, 11'h0); send(5'd9, 11'h0);
      send(5'd14, 11'h0A5); send(5'd16, 11'h009);
      for (int op = 2; op < 32; op++) begin
         if (op inside {2, 6, 7, 8, 15} || op >= 17) begin
            snap = status;
            send(5'(op), 11'h7FF);
            check("R3 unassigned opcode", {status, window, rx_en, tx_en, int_mask, rx_filter, busy},
                  {snap, 3'd7, 1'b1, 1'b1, 8'hA5, 4'h9, 1'b0});
         end
      end

      // R4 mask and filter sweeps
      for (int m = 0; m < 256; m++) begin
         send(5'd14, {3'b101, 8'(m)});
         check("R4 mask", int_mask, m);
      end
      for (int f = 0; f < 16; f++) begin
         send(5'd16, {7'h55, 4'(f)});
         check("R4 filter", rx_filter, f);
      end

      // R5 R7 R8 each event bit under three masks
      for (int i = 0; i < 8; i++) begin
         for (int k = 0; k < 3; k++) begin
            logic [7:0] m, ev_exp;
            m = (k == 0) ? 8'h00 : (k == 1) ? 8'(1 << i) : 8'hFE;
            send(5'd13, 11'h0FF);
            send(5'd14, {3'b0, m});
            check("R9 cleared before pulse", status[7:0], 0);
            cycle(1'b0, 16'h0, 8'(1 << i));
            ev_exp = 8'h00;
            if (i != 0 && i != 6) begin
               ev_exp[i] = 1'b1;
               ev_exp[0] = m[i];
            end
            check("R5 R7 event latch", status[7:0], ev_exp);
            check("R8 irq", irq, exp_irq(ev_exp, m));
            @(negedge clk);
            check("R5 event sticky", status[7:0], ev_exp);
         end
      end

      // R6 request interrupt
      send(5'd13, 11'h0FF);
      send(5'd14, 11'h040);
      send(5'd12, 11'h3FF);
      check("R6 R7 request masked", status[7:0], 8'h41);
      check("R8 irq request", irq, 1);
      send(5'd13, 11'h0FF);
      send(5'd14, 11'h000);
      send(5'd12, 11'h000);
      check("R6 request unmasked", status[7:0], 8'h40);
      check("R8 irq off", irq, 0);

      // R9 bitmask acknowledge
      send(5'd14, 11'h0FF);
      cycle(1'b1, {5'd12, 11'h0}, 8'hBE);
      check("R9 all set", status[7:0], 8'hFF);
      send(5'd13, 11'h70F);
      check("R9 ack low nibble", status[7:0], 8'hF0);
      send(5'd13, 11'h0F0);
      check("R9 ack high nibble", status[7:0], 8'h00);
      check("R8 irq after ack", irq, 0);
      send(5'd14, 11'h000);
      cycle(1'b0, 16'h0, 8'h04);
      cycle(1'b1, {5'd13, 11'h004}, 8'h04);
      check("R9 same bit ack and event", status[7:0], 8'h04);
      cycle(1'b1, {5'd13, 11'h004}, 8'h10);
      check("R9 different bits ack and event", status[7:0], 8'h10);

      // R10 busy length and ignore while busy
      send(5'd1, 11'h003);
      send(5'd0, 11'h7FF);
      for (int n = 0; n < RSTC; n++) begin
         check("R10 busy high", {busy, status[12]}, 2'b11);
         if (n == 1) cycle(1'b1, {5'd1, 11'h005}, 8'h00);
         else @(negedge clk);
      end
      check("R10 busy drops", busy, 0);
      check("R10 write ignored while busy", window, 3'd0);
      send(5'd14, 11'h0FF);
      check("R10 no busy from mask", busy, 0);

      // R11 partial resets and global reset collision
      send(5'd4, 11'h0); send(5'd9, 11'h0);
      send(5'd5, 11'h0);
      check("R11 rx reset", {rx_en, tx_en, busy}, 3'b011);
      wait_idle();
      send(5'd11, 11'h0);
      check("R11 tx reset", {rx_en, tx_en, busy}, 3'b001);
      wait_idle();
      send(5'd4, 11'h0); send(5'd1, 11'h006); send(5'd16, 11'h00F);
      cycle(1'b0, 16'h0, 8'h3E);
      cycle(1'b1, {5'd0, 11'h0}, 8'hBE);
      check("R11 global reset", {status[15:13], status[7:0], rx_en, tx_en, int_mask, rx_filter},
            {3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'h0});
      check("R8 irq after global reset", irq, 0);
      wait_idle();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule